// File: doc/BRIEF.md
# Multi-Policy Control and Status Register Bank

This block is a bank of 32-bit registers reached over a simple synchronous bus with a flat register index, a write enable with per-byte strobes and a read enable. Every bit carries an access policy fixed at elaboration through a 4-bit code per bit. The policy decides what a software write does, whether a completed read changes the bit, and which hardware event inputs (set, clear, live value) act on it. Hardware watches the bank through `cfg_q`, which shows each bit's current state.

The bus never stalls. A write lands on the rising edge where `wr_en` is high. A read is sampled on the rising edge where `rd_en` is high. `rd_data` and a one-cycle `rd_valid` appear after that edge. There is no back-pressure, so a new access may be issued every cycle. A read and a write may target the same register in the same cycle.

Top module: `regbank`

## Requirements
- R1: After reset every stored bit holds its bit of RESET_VAL (default 32'hC3A5_5A3C in every register), non-stored bits are 0, `rd_valid` is 0 and `rd_data` is 0.
- R2: A read issued on edge N gives `rd_valid`=1 and `rd_data` after edge N, holding the register's contents from before that edge's side effects. `rd_valid` is 0 after an edge with no read.
- R3: Hardware-value bits (code 0) read the `hw_val` bit present at the read edge, and software writes do not change them.
- R4: Plain bits (code 1) take the written value and hold it. Hardware inputs do not affect them.
- R5: Clear-on-one bits (code 2) clear on a written 1, ignore a written 0, and become 1 on `hw_set`. `hw_set` wins over a same-cycle clearing write.
- R6: Clear-on-zero bits (code 3) clear on a written 0, ignore a written 1, and become 1 on `hw_set`. `hw_set` wins over a same-cycle clearing write.
- R7: Set-on-one bits (code 4) set on a written 1, ignore a written 0, and become 0 on `hw_clr`. A software set wins over a same-cycle `hw_clr`.
- R8: Write-only bits (code 5) always read 0. Their `cfg_q` bit is the written value for the one cycle after the write edge, and 0 otherwise.
- R9: Read-clear bits (code 6) ignore writes, become 0 after a completed read, and become 1 on `hw_set`. `hw_set` wins over a same-cycle read.
- R10: Read-set bits (code 7) become 1 after a completed read or on `hw_set`, clear on a written 1, and ignore a written 0. Setting wins over a same-cycle clearing write.
- R11: Read-clear/write bits (code 8) take any written value and become 0 after a completed read. A same-cycle write wins over the read clear.
- R12: Reserved bits (codes 9 and 10, and unused codes 11 to 15) have no storage, always read 0, and ignore writes.
- R13: Strobe bit k gates writes to bits 8k+7..8k. A read side effect acts on all 32 bits regardless of the strobes.
- R14: In the default layout, bit b of register r uses code (32*r+b) mod 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | AW | Register index for reads and writes |
| wr_en | input | 1 | Write strobe for the indexed register |
| wr_data | input | 32 | Write data |
| wr_strb | input | 4 | Byte-lane write enables |
| rd_en | input | 1 | Read strobe for the indexed register |
| rd_data | output | 32 | Read data, valid when rd_valid is high |
| rd_valid | output | 1 | Read data returned this cycle |
| hw_set | input | 32*NREG | Per-bit hardware set events |
| hw_clr | input | 32*NREG | Per-bit hardware clear events |
| hw_val | input | 32*NREG | Per-bit live values for hardware-value bits |
| cfg_q | output | 32*NREG | Per-bit state seen by hardware |

## Verification
The hardest cases to reach are those where two agents act on one bit at the same edge: a hardware set against a software clear, a hardware clear against a software set, and a read side effect against a write to the same register. The bench reaches them with tasks that drive `hw_set` or `hw_clr` in the same cycle as a bus write, or assert `rd_en` and `wr_en` together on one index. It then reads the register back to show which side won. Because the default layout mixes all eleven codes inside every register, each readback checks every policy at once against a shadow built from the rules above.

// File: rtl/rb_pkg.sv
package rb_pkg;

  localparam int DW       = 32;
  localparam int CODE_W   = 4;
  localparam int MAX_REGS = 8;
  localparam int NUM_POL  = 11;

  typedef enum logic [CODE_W-1:0] {
    ACC_HWRO       = 4'd0,
    ACC_RW         = 4'd1,
    ACC_CLR1       = 4'd2,
    ACC_CLR0       = 4'd3,
    ACC_SET1       = 4'd4,
    ACC_WRONLY     = 4'd5,
    ACC_RDCLR      = 4'd6,
    ACC_RDSET_CLR1 = 4'd7,
    ACC_RDCLR_WR   = 4'd8,
    ACC_RES_KEEP   = 4'd9,
    ACC_RES_ZERO   = 4'd10
  } acc_e;

  // Default layout: code (32*r+b) mod 11 for bit b of register r.
  function automatic logic [MAX_REGS*DW*CODE_W-1:0] default_layout();
    logic [MAX_REGS*DW*CODE_W-1:0] t;
    t = '0;
    for (int i = 0; i < MAX_REGS*DW; i++) begin
      t[i*CODE_W +: CODE_W] = CODE_W'(i % NUM_POL);
    end
    return t;
  endfunction

  function automatic bit has_storage(logic [CODE_W-1:0] c);
    return (c == ACC_RW) || (c == ACC_CLR1) || (c == ACC_CLR0) ||
           (c == ACC_SET1) || (c == ACC_RDCLR) || (c == ACC_RDSET_CLR1) ||
           (c == ACC_RDCLR_WR);
  endfunction

endpackage

// File: rtl/rb_bit_cell.sv
module rb_bit_cell
  import rb_pkg::*;
#(
  parameter logic [CODE_W-1:0] POLICY = ACC_RW,
  parameter logic              RST    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_hit,
  input  logic wr_bit,
  input  logic rd_hit,
  input  logic hw_set,
  input  logic hw_clr,
  input  logic hw_val,
  output logic rd_bit,
  output logic q
);

  localparam bit IS_RO    = (POLICY == ACC_HWRO);
  localparam bit STORED   = has_storage(POLICY);
  localparam bit RST_EFF  = STORED ? RST : 1'b0;

  logic st, nxt;

  always_comb begin
    nxt = st;
    case (POLICY)
      ACC_HWRO:       nxt = hw_val;
      ACC_RW:         nxt = wr_hit ? wr_bit : st;
      ACC_CLR1:       nxt = hw_set ? 1'b1 : ((wr_hit && wr_bit) ? 1'b0 : st);
      ACC_CLR0:       nxt = hw_set ? 1'b1 : ((wr_hit && !wr_bit) ? 1'b0 : st);
      ACC_SET1:       nxt = (wr_hit && wr_bit) ? 1'b1 : (hw_clr ? 1'b0 : st);
      ACC_WRONLY:     nxt = wr_hit && wr_bit;
      ACC_RDCLR:      nxt = hw_set ? 1'b1 : (rd_hit ? 1'b0 : st);
      ACC_RDSET_CLR1: nxt = (hw_set || rd_hit) ? 1'b1 :
                            ((wr_hit && wr_bit) ? 1'b0 : st);
      ACC_RDCLR_WR:   nxt = wr_hit ? wr_bit : (rd_hit ? 1'b0 : st);
      default:        nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= RST_EFF;
    else        st <= nxt;
  end

  assign rd_bit = IS_RO ? hw_val : (STORED ? st : 1'b0);
  assign q      = IS_RO ? hw_val : st;

endmodule

// File: rtl/rb_reg.sv
module rb_reg
  import rb_pkg::*;
#(
  parameter logic [DW*CODE_W-1:0] ATTR_R = '0,
  parameter logic [DW-1:0]        RST_R  = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_sel,
  input  logic [DW-1:0]   wr_data,
  input  logic [DW/8-1:0] wr_strb,
  input  logic            rd_sel,
  input  logic [DW-1:0]   hw_set,
  input  logic [DW-1:0]   hw_clr,
  input  logic [DW-1:0]   hw_val,
  output logic [DW-1:0]   rd_word,
  output logic [DW-1:0]   q_word
);

  localparam int LANES = DW / 8;

  logic [LANES-1:0] lane_we;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_we[k] = wr_sel && wr_strb[k];
  end

  for (genvar b = 0; b < DW; b++) begin : g_bit
    rb_bit_cell #(
      .POLICY (ATTR_R[b*CODE_W +: CODE_W]),
      .RST    (RST_R[b])
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_hit (lane_we[b/8]),
      .wr_bit (wr_data[b]),
      .rd_hit (rd_sel),
      .hw_set (hw_set[b]),
      .hw_clr (hw_clr[b]),
      .hw_val (hw_val[b]),
      .rd_bit (rd_word[b]),
      .q      (q_word[b])
    );
  end

endmodule

// File: rtl/regbank.sv
module regbank
  import rb_pkg::*;
#(
  parameter int NREG = 4,
  parameter logic [MAX_REGS*DW*CODE_W-1:0] ATTR = default_layout(),
  parameter logic [NREG*DW-1:0] RESET_VAL = {NREG{32'hC3A5_5A3C}},
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      addr,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  input  logic [DW/8-1:0]    wr_strb,
  input  logic               rd_en,
  output logic [DW-1:0]      rd_data,
  output logic               rd_valid,
  input  logic [NREG*DW-1:0] hw_set,
  input  logic [NREG*DW-1:0] hw_clr,
  input  logic [NREG*DW-1:0] hw_val,
  output logic [NREG*DW-1:0] cfg_q
);

  logic [DW-1:0] rd_words [NREG];
  logic [DW-1:0] sel_word;
  logic          in_range;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic hit;
    assign hit = (addr == AW'(r));
    rb_reg #(
      .ATTR_R (ATTR[r*DW*CODE_W +: DW*CODE_W]),
      .RST_R  (RESET_VAL[r*DW +: DW])
    ) u_reg (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_sel  (wr_en && hit),
      .wr_data (wr_data),
      .wr_strb (wr_strb),
      .rd_sel  (rd_en && hit),
      .hw_set  (hw_set[r*DW +: DW]),
      .hw_clr  (hw_clr[r*DW +: DW]),
      .hw_val  (hw_val[r*DW +: DW]),
      .rd_word (rd_words[r]),
      .q_word  (cfg_q[r*DW +: DW])
    );
  end

  assign in_range = ({1'b0, addr} < (AW+1)'(NREG));

  always_comb begin
    sel_word = '0;
    for (int r = 0; r < NREG; r++) begin
      if (in_range && addr == AW'(r)) sel_word = rd_words[r];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= sel_word;
    end
  end

endmodule

// File: rtl/regbank_chk.sv
module regbank_chk
  import rb_pkg::*;
#(
  parameter int NREG = 4,
  parameter logic [MAX_REGS*DW*CODE_W-1:0] ATTR = default_layout(),
  localparam int AW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic [AW-1:0]      addr,
  input logic               wr_en,
  input logic [DW-1:0]      wr_data,
  input logic [DW/8-1:0]    wr_strb,
  input logic               rd_en,
  input logic [DW-1:0]      rd_data,
  input logic               rd_valid,
  input logic [NREG*DW-1:0] hw_set,
  input logic [NREG*DW-1:0] hw_clr,
  input logic [NREG*DW-1:0] hw_val,
  input logic [NREG*DW-1:0] cfg_q
);

  logic [AW-1:0] addr_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) addr_q <= '0;
    else if (rd_en) addr_q <= addr;
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  a_r2_valid_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  for (genvar r = 0; r < NREG; r++) begin : g_r
    for (genvar b = 0; b < DW; b++) begin : g_b
      localparam int I = r*DW + b;
      localparam logic [CODE_W-1:0] P = ATTR[I*CODE_W +: CODE_W];
      if (P == ACC_HWRO) begin : g_ro
        a_r3_live_value: assert property (@(posedge clk) disable iff (!rst_n)
          (rd_en && addr == AW'(r)) |=> (rd_data[b] == $past(hw_val[I])));
      end else if (P == ACC_CLR1) begin : g_c1
        a_r5_set_dominates: assert property (@(posedge clk) disable iff (!rst_n)
          hw_set[I] |=> cfg_q[I]);
      end else if (P == ACC_SET1) begin : g_s1
        a_r7_sw_set_dominates: assert property (@(posedge clk) disable iff (!rst_n)
          (wr_en && addr == AW'(r) && wr_strb[b/8] && wr_data[b]) |=> cfg_q[I]);
      end else if (P == ACC_RDCLR) begin : g_rc
        a_r9_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
          (rd_en && addr == AW'(r) && !hw_set[I]) |=> !cfg_q[I]);
      end else if (P == ACC_RDSET_CLR1) begin : g_rs
        a_r10_read_sets: assert property (@(posedge clk) disable iff (!rst_n)
          (rd_en && addr == AW'(r)) |=> cfg_q[I]);
      end else if (!has_storage(P)) begin : g_z
        a_r12_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
          (rd_valid && addr_q == AW'(r)) |-> !rd_data[b]);
      end
    end
  end

endmodule

bind regbank regbank_chk #(.NREG(NREG), .ATTR(ATTR)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
  .wr_strb(wr_strb), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
  .hw_set(hw_set), .hw_clr(hw_clr), .hw_val(hw_val), .cfg_q(cfg_q)
);

// File: tb/tb_regbank.sv
module tb_regbank;

  localparam int NREG = 4;
  localparam int AW   = 2;
  localparam logic [31:0] RSTV = 32'hC3A5_5A3C;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [AW-1:0]     addr = '0;
  logic              wr_en = 1'b0;
  logic [31:0]       wr_data = '0;
  logic [3:0]        wr_strb = '0;
  logic              rd_en = 1'b0;
  logic [31:0]       rd_data;
  logic              rd_valid;
  logic [NREG*32-1:0] hw_set = '0;
  logic [NREG*32-1:0] hw_clr = '0;
  logic [NREG*32-1:0] hw_val = '0;
  logic [NREG*32-1:0] cfg_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] sh [NREG];

  always #5 clk = ~clk;

  regbank #(.NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .wr_strb(wr_strb), .rd_en(rd_en), .rd_data(rd_data), .rd_valid(rd_valid),
    .hw_set(hw_set), .hw_clr(hw_clr), .hw_val(hw_val), .cfg_q(cfg_q)
  );

  // R14 layout
  function automatic int pol(int r, int b);
    return (32*r + b) % 11;
  endfunction

  function automatic bit stored(int p);
    return p inside {1, 2, 3, 4, 6, 7, 8};
  endfunction

  function automatic logic [31:0] mask_of(int r, int p);
    logic [31:0] m = '0;
    for (int b = 0; b < 32; b++) m[b] = (pol(r, b) == p);
    return m;
  endfunction

  function automatic logic [31:0] view(int r);
    logic [31:0] v = '0;
    for (int b = 0; b < 32; b++) begin
      if (pol(r, b) == 0) v[b] = hw_val[r*32+b];
      else if (stored(pol(r, b))) v[b] = sh[r][b];
    end
    return v;
  endfunction

  function automatic logic nextbit(int p, logic q, logic w, logic d,
                                   logic rd, logic hs, logic hc);
    case (p)
      1: return w ? d : q;
      2: return hs ? 1'b1 : ((w && d) ? 1'b0 : q);
      3: return hs ? 1'b1 : ((w && !d) ? 1'b0 : q);
      4: return (w && d) ? 1'b1 : (hc ? 1'b0 : q);
      6: return hs ? 1'b1 : (rd ? 1'b0 : q);
      7: return (hs || rd) ? 1'b1 : ((w && d) ? 1'b0 : q);
      8: return w ? d : (rd ? 1'b0 : q);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One bus cycle on register r; updates the shadow, checks the read.
  task automatic op(string tag, int r, bit rd, bit wr, logic [31:0] d,
                    logic [3:0] strb, logic [31:0] hs, logic [31:0] hc);
    logic [31:0] exp;
    @(negedge clk);
    exp = view(r);
    addr = AW'(r); rd_en = rd; wr_en = wr; wr_data = d; wr_strb = strb;
    hw_set[r*32 +: 32] = hs; hw_clr[r*32 +: 32] = hc;
    for (int b = 0; b < 32; b++)
      sh[r][b] = nextbit(pol(r, b), sh[r][b], wr && strb[b/8], d[b], rd, hs[b], hc[b]);
    @(negedge clk);
    rd_en = 0; wr_en = 0; wr_strb = '0;
    hw_set = '0; hw_clr = '0;
    if (rd) begin
      chk({tag, " rd_valid R2"}, {31'b0, rd_valid}, 32'd1);
      chk(tag, rd_data, exp);
    end
  endtask

  task automatic t_reset();
    chk("R1 rd_valid after reset", {31'b0, rd_valid}, 32'd0);
    chk("R1 rd_data after reset", rd_data, 32'd0);
    for (int r = 0; r < NREG; r++) op("R1 R14 reset value", r, 1, 0, 0, 4'h0, 0, 0);
  endtask

  task automatic t_write_ones();
    for (int r = 0; r < NREG; r++) begin
      op("R4 write ones", r, 0, 1, 32'hFFFF_FFFF, 4'hF, 0, 0);
      op("R4 R5 R7 R11 readback", r, 1, 0, 0, 4'h0, 0, 0);
      op("R9 R10 second read", r, 1, 0, 0, 4'h0, 0, 0);
      op("R12 reserved zero", r, 1, 0, 32'hFFFF_FFFF, 4'h0, 0, 0);
      chk("R12 R8 zero-read bits", rd_data & (mask_of(r,5)|mask_of(r,9)|mask_of(r,10)), 0);
    end
  endtask

  task automatic t_write_zero();
    for (int r = 0; r < NREG; r++) begin
      op("R6 write zeros", r, 0, 1, 32'h0, 4'hF, 0, 0);
      op("R6 R4 readback", r, 1, 0, 0, 4'h0, 0, 0);
    end
  endtask

  task automatic t_strobe();
    op("R13 prep", 1, 0, 1, 32'h0, 4'hF, 0, 0);
    op("R13 lanes 0 2", 1, 0, 1, 32'hFFFF_FFFF, 4'b0101, 0, 0);
    op("R13 strobed readback", 1, 1, 0, 0, 4'h0, 0, 0);
    op("R13 hw set", 2, 0, 0, 0, 4'h0, 32'hFFFF_FFFF, 0);
    op("R13 read ignores strobes", 2, 1, 0, 0, 4'h0, 0, 0);
    op("R13 all lanes cleared", 2, 1, 0, 0, 4'h0, 0, 0);
  endtask

  task automatic t_ro();
    hw_val = {32'h1234_5678, 32'h9ABC_DEF0, 32'h0F0F_F0F0, 32'hA5A5_5A5A};
    for (int r = 0; r < NREG; r++) begin
      op("R3 write ignored", r, 0, 1, ~hw_val[r*32 +: 32], 4'hF, 0, 0);
      op("R3 hw value read", r, 1, 0, 0, 4'h0, 0, 0);
    end
    hw_val = '0;
  endtask

  task automatic t_conflict();
    for (int r = 0; r < NREG; r++) begin
      op("R5 set vs w1 clear", r, 0, 1, 32'hFFFF_FFFF, 4'hF, 32'hFFFF_FFFF, 0);
      op("R5 R10 readback", r, 1, 0, 0, 4'h0, 0, 0);
      op("R6 set vs w0 clear", r, 0, 1, 32'h0, 4'hF, 32'hFFFF_FFFF, 0);
      op("R6 readback", r, 1, 0, 0, 4'h0, 0, 0);
      op("R7 sw set vs hw clr", r, 0, 1, 32'hFFFF_FFFF, 4'hF, 0, 32'hFFFF_FFFF);
      op("R7 readback", r, 1, 0, 0, 4'h0, 0, 0);
      op("R7 hw clr alone", r, 0, 0, 0, 4'h0, 0, 32'hFFFF_FFFF);
      op("R7 R9 readback", r, 1, 0, 0, 4'h0, 0, 0);
      op("R9 set vs read", r, 1, 0, 0, 4'h0, 32'hFFFF_FFFF, 0);
      op("R9 R10 after set+read", r, 1, 0, 0, 4'h0, 0, 0);
    end
  endtask

  task automatic t_wo();
    logic [31:0] m;
    for (int r = 0; r < NREG; r++) begin
      m = mask_of(r, 5);
      op("R8 write", r, 0, 1, 32'hFFFF_FFFF, 4'b0011, 0, 0);
      chk("R8 pulse", cfg_q[r*32 +: 32] & m, m & 32'h0000_FFFF);
      @(negedge clk);
      chk("R8 pulse ends", cfg_q[r*32 +: 32] & m, 32'h0);
      op("R8 reads zero", r, 1, 0, 0, 4'h0, 0, 0);
    end
  endtask

  task automatic t_rcw();
    for (int r = 0; r < NREG; r++) begin
      op("R11 prep", r, 0, 1, 32'h0, 4'hF, 0, 0);
      op("R2 R11 read+write old data", r, 1, 1, 32'hFFFF_FFFF, 4'hF, 0, 0);
      op("R11 write wins", r, 1, 0, 0, 4'h0, 0, 0);
      op("R11 cleared by read", r, 1, 0, 0, 4'h0, 0, 0);
    end
  endtask

  initial begin
    for (int r = 0; r < NREG; r++)
      for (int b = 0; b < 32; b++) sh[r][b] = stored(pol(r, b)) ? RSTV[b] : 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_write_ones();
    t_write_zero();
    t_strobe();
    t_ro();
    t_conflict();
    t_wo();
    t_rcw();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule